// File: doc/BRIEF.md
# Peak program level detector

This block follows the loudness of one channel of signed 24-bit audio the way a peak program meter does. Each valid sample is rectified to a 23-bit magnitude. The magnitude of the most negative code saturates to the largest positive magnitude. The largest magnitude seen since the last millisecond tick is kept. On each tick it is merged into a held level. The held level first loses a fixed fraction, about 20 dB over 1.5 s, and then takes the larger of that decayed value and the new peak. So a loud sample is never missed, and quiet passages fall away smoothly.

The level word is published once per tick, together with a one-cycle valid strobe. Apart from that, the block gives a one-cycle clip pulse whenever a valid sample sits at either full-scale code. The tick is supplied from outside, normally once every millisecond. A later stage converts the level to decibels for display.

Top module: `ppm_level_detector`

## Requirements
- R1: The magnitude of a sample is its absolute value in 23 bits. Code 0x800000 gives 0x7FFFFF.
- R2: On a cycle with `ms_tick` high, the held level becomes the larger of two values: the decayed held level, and the largest magnitude of all valid samples since the previous tick. The second value includes a valid sample in the tick cycle itself.
- R3: The decayed value is floor(held × 65435 / 65536). This is a multiply by a 16-bit fraction, with truncation toward zero.
- R4: `level_o` and `level_vld_o` change only on the cycle after a tick. `level_vld_o` is high for exactly that one cycle, and `level_o` holds steady at all other times.
- R5: `clip_o` is high for exactly the cycle after a valid sample equal to 0x7FFFFF or 0x800000, and is low otherwise.
- R6: A sample presented with `smp_vld` low changes neither the held level nor the clip output.
- R7: The running maximum is cleared at every tick. A tick with no new samples therefore yields only the decayed level.
- R8: A synchronous reset clears the held level, the running maximum, `level_vld_o` and `clip_o` to zero.
- R9: Repeated ticks without samples drive any held level down to exactly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample valid strobe |
| smp_data | input | 24 | Signed two's-complement audio sample |
| ms_tick | input | 1 | Millisecond update tick, one cycle wide |
| level_o | output | 23 | Held peak level |
| level_vld_o | output | 1 | High for the cycle in which a new level is published |
| clip_o | output | 1 | High for one cycle after a full-scale sample |

## Verification
The hardest behaviour to reach from the ports is the tail of the decay. There, truncation finally takes a small held level down to zero, which takes thousands of ticks after a full-scale load. The bench loads the level to 0x7FFFFF. It then issues a long run of bare ticks and compares every published level with an arithmetic model. At the end it checks that the level has reached zero. Samples that arrive in the same cycle as a tick, and sample magnitudes below the decayed level, are also driven on purpose. These cases exercise both sides of the merge.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
    localparam int SMP_W   = 24;
    localparam int LVL_W   = SMP_W - 1;
    localparam int COEF_W  = 16;
    // exp(-1/650) scaled by 2^16
    localparam int DECAY_K = 65435;
endpackage

// File: rtl/ppm_rectify.sv
module ppm_rectify #(
    parameter int SMP_W = ppm_pkg::SMP_W,
    localparam int LVL_W = SMP_W - 1
) (
    input  logic [SMP_W-1:0] sample_i,
    output logic [LVL_W-1:0] mag_o,
    output logic             full_o
);
    localparam logic [SMP_W-1:0] POS_FS = {1'b0, {(SMP_W-1){1'b1}}};
    localparam logic [SMP_W-1:0] NEG_FS = {1'b1, {(SMP_W-1){1'b0}}};
    localparam logic [SMP_W-1:0] ONE    = {{(SMP_W-1){1'b0}}, 1'b1};

    logic [SMP_W-1:0] negated;

    always_comb begin
        negated = (~sample_i) + ONE;
        if (sample_i == NEG_FS) begin
            mag_o = {LVL_W{1'b1}};
        end else if (sample_i[SMP_W-1]) begin
            mag_o = negated[LVL_W-1:0];
        end else begin
            mag_o = sample_i[LVL_W-1:0];
        end
        full_o = (sample_i == POS_FS) || (sample_i == NEG_FS);
    end
endmodule

// File: rtl/ppm_decay.sv
module ppm_decay #(
    parameter int LVL_W  = ppm_pkg::LVL_W,
    parameter int COEF_W = ppm_pkg::COEF_W,
    parameter int K      = ppm_pkg::DECAY_K,
    localparam int PROD_W = LVL_W + COEF_W
) (
    input  logic [LVL_W-1:0] level_i,
    output logic [LVL_W-1:0] level_o
);
    localparam logic [COEF_W-1:0] KV = COEF_W'(K);

    logic [PROD_W-1:0] product;

    always_comb begin
        product = PROD_W'(level_i) * PROD_W'(KV);
        level_o = product[PROD_W-1:COEF_W];
    end
endmodule

// File: rtl/ppm_level_detector.sv
module ppm_level_detector #(
    parameter int SMP_W  = ppm_pkg::SMP_W,
    parameter int COEF_W = ppm_pkg::COEF_W,
    parameter int K      = ppm_pkg::DECAY_K,
    localparam int LVL_W = SMP_W - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             ms_tick,
    output logic [LVL_W-1:0] level_o,
    output logic             level_vld_o,
    output logic             clip_o
);
    typedef struct packed {
        logic [LVL_W-1:0] held;
        logic [LVL_W-1:0] peak;
        logic             lvl_vld;
        logic             clip;
    } state_t;

    state_t state_d, state_q;

    logic [LVL_W-1:0] mag;
    logic             full;
    logic [LVL_W-1:0] decayed;
    logic [LVL_W-1:0] peak_now;
    logic [LVL_W-1:0] candidate;

    ppm_rectify #(.SMP_W(SMP_W)) u_rect (
        .sample_i (smp_data),
        .mag_o    (mag),
        .full_o   (full)
    );

    ppm_decay #(.LVL_W(LVL_W), .COEF_W(COEF_W), .K(K)) u_decay (
        .level_i (state_q.held),
        .level_o (decayed)
    );

    assign peak_now = state_q.peak;

    always_comb begin
        state_d   = state_q;
        candidate = state_q.peak;
        if (smp_vld && (mag > candidate)) begin
            candidate = mag;
        end
        state_d.clip    = smp_vld && full;
        state_d.lvl_vld = ms_tick;
        if (ms_tick) begin
            state_d.held = (candidate > decayed) ? candidate : decayed;
            state_d.peak = '0;
        end else begin
            state_d.peak = candidate;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign level_o     = state_q.held;
    assign level_vld_o = state_q.lvl_vld;
    assign clip_o      = state_q.clip;
endmodule

// File: rtl/ppm_level_checker.sv
module ppm_level_checker #(
    parameter int SMP_W = ppm_pkg::SMP_W,
    localparam int LVL_W = SMP_W - 1
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_vld,
    input logic [SMP_W-1:0] smp_data,
    input logic             ms_tick,
    input logic [LVL_W-1:0] level_o,
    input logic             level_vld_o,
    input logic             clip_o,
    input logic [LVL_W-1:0] peak_now
);
    localparam logic [SMP_W-1:0] POS_FS = {1'b0, {(SMP_W-1){1'b1}}};
    localparam logic [SMP_W-1:0] NEG_FS = {1'b1, {(SMP_W-1){1'b0}}};

    assert_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        ms_tick |=> level_vld_o);
    assert_no_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !ms_tick |=> !level_vld_o);
    assert_level_steady_R4: assert property (@(posedge clk) disable iff (rst)
        !ms_tick |=> $stable(level_o));
    assert_clip_set_R5: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && (smp_data == POS_FS || smp_data == NEG_FS)) |=> clip_o);
    assert_clip_clear_R5: assert property (@(posedge clk) disable iff (rst)
        !(smp_vld && (smp_data == POS_FS || smp_data == NEG_FS)) |=> !clip_o);
    assert_peak_kept_R2: assert property (@(posedge clk) disable iff (rst)
        ms_tick |=> (level_o >= $past(peak_now)));
    assert_peak_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        (ms_tick && !smp_vld) |=> (peak_now == '0));
    assert_reset_R8: assert property (@(posedge clk)
        rst |=> (level_o == '0 && !clip_o && !level_vld_o && peak_now == '0));
endmodule

bind ppm_level_detector ppm_level_checker #(.SMP_W(SMP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .smp_vld     (smp_vld),
    .smp_data    (smp_data),
    .ms_tick     (ms_tick),
    .level_o     (level_o),
    .level_vld_o (level_vld_o),
    .clip_o      (clip_o),
    .peak_now    (peak_now)
);

// File: tb/sim_ppm_level_detector.sv
`timescale 1ns/1ps
module sim_ppm_level_detector;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld = 1'b0;
    logic [23:0] smp_data = '0;
    logic        ms_tick = 1'b0;
    logic [22:0] level_o;
    logic        level_vld_o;
    logic        clip_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    longint m_held = 0;
    longint m_peak = 0;

    always #10 clk = ~clk;

    ppm_level_detector u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
        .ms_tick(ms_tick), .level_o(level_o), .level_vld_o(level_vld_o),
        .clip_o(clip_o)
    );

    function automatic longint mag_of(input logic [23:0] s);
        longint v;
        v = longint'($signed(s));
        if (v < 0) v = -v;
        if (v > 64'h7FFFFF) v = 64'h7FFFFF;
        return v;
    endfunction

    function automatic bit is_full(input logic [23:0] s);
        return (s == 24'h7FFFFF) || (s == 24'h800000);
    endfunction

    task automatic chk(input longint act, input longint exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_sample(input logic [23:0] s, input bit v, input string tag);
        @(negedge clk);
        smp_vld = v; smp_data = s;
        if (v && mag_of(s) > m_peak) m_peak = mag_of(s);
        @(negedge clk);
        smp_vld = 1'b0;
        chk(longint'(clip_o), longint'(v && is_full(s)), tag);
        chk(longint'(level_vld_o), 0, "R4 strobe idle");
        chk(longint'(level_o), m_held, "R6 level untouched between ticks");
    endtask

    task automatic do_tick(input bit v, input logic [23:0] s, input string tag);
        longint cand, dec;
        @(negedge clk);
        ms_tick = 1'b1; smp_vld = v; smp_data = s;
        cand = m_peak;
        if (v && mag_of(s) > cand) cand = mag_of(s);
        dec = (m_held * 65435) >> 16;
        m_held = (cand > dec) ? cand : dec;
        m_peak = 0;
        @(negedge clk);
        ms_tick = 1'b0; smp_vld = 1'b0;
        chk(longint'(level_vld_o), 1, "R4 strobe after tick");
        chk(longint'(level_o), m_held, tag);
        chk(longint'(clip_o), longint'(v && is_full(s)), "R5 clip in tick cycle");
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        m_held = 0; m_peak = 0;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(longint'(level_o), 0, "R8 reset level");
        chk(longint'(level_vld_o), 0, "R8 reset strobe");
        chk(longint'(clip_o), 0, "R8 reset clip");
        rst = 1'b0;

        // R1 and R2: attack sweep over bit positions, both signs, in and out of the tick cycle
        for (int k = 0; k < 23; k++) begin
            do_reset();
            put_sample(24'((1 << k) + k), 1'b1, "R1 positive sample clip");
            do_tick(1'b0, '0, "R2 positive magnitude");
            do_reset();
            put_sample(24'(-((1 << k) + k)), 1'b1, "R1 negative sample clip");
            put_sample(24'(3), 1'b1, "R2 smaller sample clip");
            do_tick(1'b0, '0, "R1 negative magnitude");
            do_tick(1'b1, 24'(-(k * 1000 + 7)), "R2 sample in tick cycle");
        end

        // R1 and R5: full-scale codes and their neighbours
        do_reset();
        put_sample(24'h800000, 1'b1, "R5 clip on 0x800000");
        do_tick(1'b0, '0, "R1 0x800000 saturates");
        chk(longint'(level_o), 64'h7FFFFF, "R1 saturated value");
        put_sample(24'h7FFFFF, 1'b1, "R5 clip on 0x7FFFFF");
        put_sample(24'h7FFFFE, 1'b1, "R5 no clip on 0x7FFFFE");
        put_sample(24'h800001, 1'b1, "R5 no clip on 0x800001");
        do_tick(1'b1, 24'h7FFFFF, "R2 full scale in tick cycle");

        // R6: invalid samples ignored
        do_reset();
        put_sample(24'h7FFFFF, 1'b0, "R6 no clip when invalid");
        do_tick(1'b0, 24'h7FFFFF, "R6 invalid sample at tick ignored");
        chk(longint'(level_o), 0, "R6 level stays zero");

        // R3 and R7: peak below decayed level, then bare ticks
        do_reset();
        do_tick(1'b1, 24'h400000, "R2 load");
        put_sample(24'h100, 1'b1, "R3 small sample clip");
        do_tick(1'b0, '0, "R3 decay dominates small peak");
        put_sample(24'h3FFFFF, 1'b1, "R7 big sample clip");
        do_tick(1'b0, '0, "R2 big peak merged");
        do_tick(1'b0, '0, "R7 peak cleared after tick");

        // R9: long decay from full scale down to zero
        do_reset();
        do_tick(1'b1, 24'h7FFFFF, "R9 full-scale load");
        for (int t = 0; t < 13000; t++) begin
            do_tick(1'b0, '0, "R3 decay step");
        end
        chk(longint'(level_o), 0, "R9 level reached zero");

        // R8: reset mid-operation
        do_tick(1'b1, 24'h123456, "R2 reload");
        @(negedge clk); rst = 1'b1; smp_vld = 1'b1; smp_data = 24'h7FFFFF;
        @(negedge clk); smp_vld = 1'b0;
        chk(longint'(level_o), 0, "R8 reset clears level");
        chk(longint'(clip_o), 0, "R8 reset clears clip");
        @(negedge clk); rst = 1'b0;
        m_held = 0; m_peak = 0;
        do_tick(1'b0, '0, "R8 running max cleared by reset");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule